// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of two-bit saturating counters and reads one counter per prediction. The counter is chosen by an index formed from the branch address, combined by XOR with recent branch outcomes held in an eight-bit global history register. A four-bit control word sets how many history bits take part in the hash, so the same hardware can behave as a pure address-indexed predictor, as a full global-history predictor, or as anything in between.

A prediction request carries a branch address. One clock later the block returns the predicted direction together with the table index it used. The caller keeps that index and returns it on the update port when the branch resolves. Each update trains the counter at that index and shifts the real outcome into the history.

Top module: `gshare_predictor`

## Requirements
- R1: During and after a synchronous reset (rst high at a rising edge), the history register holds zero and every counter holds 1 (weakly not taken). The first prediction for any address is therefore not taken, and pred_valid_o is 0 while reset is held.
- R2: When hist_cfg_i[3] is 1, all eight history bits take part in the hash, whatever hist_cfg_i[2:0] holds.
- R3: When hist_cfg_i[3] is 0, hist_cfg_i[2:0] = N (0 to 7) selects history bits [N-1:0]. All higher history bits are forced to zero before the XOR.
- R4: When hist_cfg_i is 4'b0000, the index equals pred_pc_i[10:2], whatever the history holds.
- R5: The index is pred_pc_i[10:2] XOR the masked history, zero-extended to 9 bits, with history bit 0 aligned to index bit 0.
- R6: The prediction is taken when the counter is 2 or 3, and not taken when it is 0 or 1.
- R7: An update with upd_taken_i=1 increments the counter and stops at 3. An update with upd_taken_i=0 decrements it and stops at 0.
- R8: Each update shifts the history left by one, places upd_taken_i in bit 0 and drops bit 7. Without an update, the history holds its value.
- R9: An update trains the counter at upd_index_i, whatever index the present history and address would produce.
- R10: When a prediction and an update address the same entry in the same cycle, the prediction returns the counter value from before the update. The prediction also uses the history from before that cycle's shift.
- R11: pred_valid_o, pred_taken_o and pred_index_o are registered. They appear one cycle after the request, and pred_valid_o is 0 in the cycle after a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hist_cfg_i | input | 4 | History-length control: bit 3 = use all eight bits, bits 2:0 = bit count |
| pred_valid_i | input | 1 | Prediction request |
| pred_pc_i | input | 32 | Branch address to predict |
| pred_valid_o | output | 1 | Prediction result valid |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_index_o | output | 9 | Table index used for this prediction |
| upd_valid_i | input | 1 | Branch resolved: train the counter and shift the history |
| upd_index_i | input | 9 | Index returned when this branch was predicted |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 9-bit index (512 counters) and 8 history bits. With a 9-bit index the zero-extended history covers the low eight index bits, so every control setting from none to all eight bits changes observable index bits. The bench drives all sixteen control codes over a history it has built up itself. It trains a single entry past both saturation points, and it collides prediction and update on the same entry in the same cycle.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MIN     = 2'd0;
  localparam ctr_t CTR_MAX     = 2'd3;
  localparam ctr_t CTR_WEAK_NT = 2'd1;

  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    ctr_t r;
    if (up) r = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
    else    r = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/gs_history.sv
module gs_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
  end

  assign hist_o = hist_q;

  assert_hist_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q));
  assert_hist_newbit_R8: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist_q[0] == $past(shift_bit));
  assert_hist_age_R8: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));
endmodule

// File: rtl/gs_hash.sv
module gs_hash #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 9,
  parameter int HIST_W = 8,
  parameter int CFG_W  = 4
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  input  logic [CFG_W-1:0]  cfg,
  output logic [IDX_W-1:0]  idx
);
  localparam int CNT_W = $clog2(HIST_W + 1);

  logic [CNT_W-1:0]  use_cnt;
  logic [HIST_W-1:0] keep_mask;
  logic [HIST_W-1:0] hist_sel;
  logic [IDX_W-1:0]  hist_ext;
  logic [IDX_W-1:0]  pc_part;

  always_comb begin
    if (cfg[CFG_W-1]) use_cnt = CNT_W'(HIST_W);
    else              use_cnt = CNT_W'(cfg[CFG_W-2:0]);
  end

  for (genvar b = 0; b < HIST_W; b++) begin : g_mask
    assign keep_mask[b] = (CNT_W'(b) < use_cnt);
  end

  assign hist_sel = hist & keep_mask;

  if (IDX_W >= HIST_W) begin : g_ext_pad
    assign hist_ext = {{(IDX_W-HIST_W){1'b0}}, hist_sel};
  end else begin : g_ext_cut
    assign hist_ext = hist_sel[IDX_W-1:0];
  end

  assign pc_part = pc[IDX_W+1:2];
  assign idx     = pc_part ^ hist_ext;

  always_comb begin
    if (cfg == '0) assert_nohist_R4: assert (idx == pc_part);
    if (cfg[CFG_W-1]) assert_full_mask_R2: assert (keep_mask == '1);
    else assert_mask_count_R3: assert ($countones(keep_mask) == int'(cfg[CFG_W-2:0]));
  end
endmodule

// File: rtl/gs_counter_table.sv
module gs_counter_table
  import gs_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];
  ctr_t rd_q;
  ctr_t wr_old;

  assign wr_old = ctr_q[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < DEPTH; e++) ctr_q[e] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= ctr_step(wr_old, wr_up);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= CTR_WEAK_NT;
    else if (rd_en) rd_q <= ctr_q[rd_idx];
  end

  assign rd_ctr_o = rd_q;

  assert_sat_top_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_up && wr_old == CTR_MAX) |=> ctr_q[$past(wr_idx)] == CTR_MAX);
  assert_sat_bottom_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_up && wr_old == CTR_MIN) |=> ctr_q[$past(wr_idx)] == CTR_MIN);
  assert_read_old_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && rd_idx == wr_idx) |=> rd_ctr_o == $past(wr_old));
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gs_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 9,
  parameter int HIST_W = 8,
  parameter int CFG_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] hist_cfg_i,
  input  logic             pred_valid_i,
  input  logic [PC_W-1:0]  pred_pc_i,
  output logic             pred_valid_o,
  output logic             pred_taken_o,
  output logic [IDX_W-1:0] pred_index_o,
  input  logic             upd_valid_i,
  input  logic [IDX_W-1:0] upd_index_i,
  input  logic             upd_taken_i
);
  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  look_idx;
  ctr_t              look_ctr;
  logic              valid_q;
  logic [IDX_W-1:0]  index_q;

  gs_history #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (upd_valid_i),
    .shift_bit (upd_taken_i),
    .hist_o    (hist)
  );

  gs_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .CFG_W(CFG_W)) u_hash (
    .pc   (pred_pc_i),
    .hist (hist),
    .cfg  (hist_cfg_i),
    .idx  (look_idx)
  );

  gs_counter_table #(.IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (pred_valid_i),
    .rd_idx   (look_idx),
    .rd_ctr_o (look_ctr),
    .wr_en    (upd_valid_i),
    .wr_idx   (upd_index_i),
    .wr_up    (upd_taken_i)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      index_q <= '0;
    end else begin
      valid_q <= pred_valid_i;
      if (pred_valid_i) index_q <= look_idx;
    end
  end

  assign pred_valid_o = valid_q;
  assign pred_index_o = index_q;
  assign pred_taken_o = look_ctr[1];

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    pred_valid_i |=> pred_valid_o);
  assert_valid_drops_R11: assert property (@(posedge clk) disable iff (rst)
    !pred_valid_i |=> !pred_valid_o);
  assert_index_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !pred_valid_i |=> $stable(pred_index_o));
endmodule

// File: tb/test_gshare_predictor.sv
module test_gshare_predictor;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] cfg;
  logic       pv;
  logic [31:0] pc;
  logic       uv;
  logic [8:0] uidx;
  logic       ut;
  logic       o_valid;
  logic       o_taken;
  logic [8:0] o_index;

  int n_checks = 0;
  int n_fail   = 0;
  int m_ctr [512];
  int m_hist;
  bit done = 0;

  always #2.5 clk = ~clk;

  gshare_predictor i_gshare_predictor (
    .clk          (clk),
    .rst          (rst),
    .hist_cfg_i   (cfg),
    .pred_valid_i (pv),
    .pred_pc_i    (pc),
    .pred_valid_o (o_valid),
    .pred_taken_o (o_taken),
    .pred_index_o (o_index),
    .upd_valid_i  (uv),
    .upd_index_i  (uidx),
    .upd_taken_i  (ut)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_idx(input int pcv, input int c);
    int n;
    n = c[3] ? 8 : (c & 7);
    return ((pcv >> 2) & 511) ^ (m_hist & ((1 << n) - 1));
  endfunction

  // one cycle: drive at negedge, model at edge, compare at next negedge
  task automatic step(input string tag, input bit p, input int pcv, input int c,
                      input bit u, input int ui, input bit t);
    int e_idx;
    int e_tk;
    pv = p; pc = pcv; cfg = 4'(c); uv = u; uidx = 9'(ui); ut = t;
    e_idx = model_idx(pcv, c);
    e_tk  = (m_ctr[e_idx] >= 2) ? 1 : 0;
    @(posedge clk);
    if (u) begin
      if (t && m_ctr[ui] < 3) m_ctr[ui]++;
      if (!t && m_ctr[ui] > 0) m_ctr[ui]--;
      m_hist = ((m_hist << 1) | int'(t)) & 255;
    end
    @(negedge clk);
    check({tag, " valid"}, int'(o_valid), int'(p));
    if (p) begin
      check({tag, " index"}, int'(o_index), e_idx);
      check({tag, " taken"}, int'(o_taken), e_tk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pv = 0; pc = 0; cfg = 0; uv = 0; uidx = 0; ut = 0;
    for (int e = 0; e < 512; e++) m_ctr[e] = 1;
    m_hist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", int'(o_valid), 0);
    check("R1 reset taken", int'(o_taken), 0);
    rst = 1'b0;

    // R1: fresh table, zero history, full history use
    step("R1", 1, 32'h0000_1000, 8, 0, 0, 0);
    step("R1", 1, 32'h0000_27FC, 8, 0, 0, 0);

    // R8/R10: build history while predicting; prediction sees pre-shift history
    for (int k = 0; k < 10; k++)
      step("R8", 1, 32'h0000_0400 + k * 4, 8, 1, 9'h100 + k, (k % 3) != 1);

    // R4: no history, index is address bits only
    step("R4", 1, 32'h0000_0A5C, 0, 0, 0, 0);
    step("R4", 1, 32'hFFFF_FFFC, 0, 0, 0, 0);

    // R2 and R5: top control bit set, lower bits irrelevant
    for (int c = 8; c < 16; c++)
      step("R2", 1, 32'h0000_1234 + c * 16, c, 0, 0, 0);

    // R3 and R5: partial history counts
    for (int c = 1; c < 8; c++)
      step("R3", 1, 32'h0000_0FF0, c, 0, 0, 0);

    // R6/R7/R10: train one entry up past 3, then down past 0, colliding with prediction
    for (int k = 0; k < 5; k++) step("R7", 1, 32'h0000_0158, 0, 1, 9'h056, 1);
    step("R6", 1, 32'h0000_0158, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) step("R7", 1, 32'h0000_0158, 0, 1, 9'h056, 0);
    step("R6", 1, 32'h0000_0158, 0, 0, 0, 0);
    step("R10", 1, 32'h0000_0158, 0, 1, 9'h056, 1);
    step("R10", 1, 32'h0000_0158, 0, 1, 9'h056, 1);
    step("R6", 1, 32'h0000_0158, 0, 0, 0, 0);

    // R9: train an index unrelated to the current address and history
    step("R9", 1, 32'h0000_0000, 8, 1, 9'h1AB, 1);
    step("R9", 1, 32'h0000_06AC, 0, 0, 0, 0);

    // R11: idle cycles
    step("R11", 0, 32'h0000_0000, 0, 0, 0, 0);
    step("R11", 0, 32'h0000_0010, 8, 1, 9'h003, 0);
    step("R11", 1, 32'h0000_0010, 8, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule